// File: doc/BRIEF.md
# Register Renamer with Free-List Allocation

This block sits between the decoder and the schedulers of an out-of-order core. Every cycle it may receive a group of up to three micro-operations. For each one it turns the two architectural source register numbers into physical register numbers by reading an alias table. It also gives each micro-operation that writes a result a fresh physical register. That register comes from a first-in, first-out list of unused physical registers, so register numbers are handed out in whatever order they were released, not in counting order.

Each micro-operation also takes one slot in a ring of status entries. The ring allocates slots in order, and a slot's index is the micro-operation's age number. A slot holds only three things: a completion flag, whether the operation writes a register, and the physical register that the destination was mapped to before this operation. Completion arrives through a write port that carries an age number. Each cycle, up to three of the oldest completed entries leave the ring in order. For every leaving entry that writes a register, its superseded physical register goes back to the free list. No result data moves anywhere.

If the free list or the ring cannot hold every micro-operation in the group, the whole group stalls and nothing in the group is renamed. With default parameters there are 8 architectural registers, 128 physical registers and 126 ring entries.

Top module: `rename_alloc`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free list holds physical registers 8 to 127, and they come out in ascending order.
- R2: Each valid slot's source outputs give the current mapping of the named architectural register. If an earlier valid slot in the same group writes that register, the output is that slot's new physical register instead. When several earlier slots write it, the nearest earlier slot wins.
- R3: Valid slots with a destination take physical registers from the head of the free list, in slot order, and the alias table then points at them. The mapping each such slot replaces is recorded. This is the previous table entry, or the new register of an earlier slot in the same group that wrote the same architectural register.
- R4: Valid slots receive consecutive age numbers in slot order, counting modulo 126 and continuing from the last accepted group.
- R5: When a group needs more destination registers than the free list holds, stall is high, no slot of the group is accepted, and no state changes.
- R6: When a group has more valid slots than there are free ring entries, stall is high and the group is not accepted.
- R7: A pulse on the completion port marks the entry with that age number as completed.
- R8: Retirement outputs report, in age order, the oldest in-flight entries that are completed and contiguous from the oldest, at most three per cycle. An entry leaves the ring on the clock edge that ends the cycle in which it is reported.
- R9: A retiring entry that writes a register reports its superseded physical register on the free outputs. That register joins the tail of the free list and can be handed out from the following cycle onward.
- R10: Valid slots without a destination take no physical register and can be accepted even when the free list is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_valid | input | 3 | Per-slot valid for the incoming group |
| grp_has_dst | input | 3 | Per-slot flag: the micro-operation writes a register |
| grp_src_a | input | 9 | First source architectural register, 3 bits per slot |
| grp_src_b | input | 9 | Second source architectural register, 3 bits per slot |
| grp_dst | input | 9 | Destination architectural register, 3 bits per slot |
| grp_stall | output | 1 | Group rejected this cycle |
| grp_phys_a | output | 21 | Physical register for first source, 7 bits per slot |
| grp_phys_b | output | 21 | Physical register for second source, 7 bits per slot |
| grp_phys_dst | output | 21 | Newly allocated physical destination, 7 bits per slot (zero if none) |
| grp_seq | output | 21 | Age number per slot, 7 bits per slot |
| done_valid | input | 1 | Completion write strobe |
| done_seq | input | 7 | Age number of the completed entry |
| retire_valid | output | 3 | Per-slot retirement valid, slot 0 is oldest |
| retire_seq | output | 21 | Age number of each retiring entry |
| free_valid | output | 3 | Retiring entry returns a physical register |
| free_preg | output | 21 | Superseded physical register being returned |

## Verification
Allocation and retirement often fall in the same cycle. Then the free list is popped at its head and pushed at its tail in one edge, and the ring moves its oldest and newest pointers together. A long random phase provokes this overlap. It gives slots a small pool of architectural registers and fires a completion in most cycles, so the ring stays near full while registers keep coming back. A behavioural model built from queues predicts stall, every renamed field and every retirement in each cycle. Because registers released in a cycle can be handed out only afterwards, the model has to pop before it appends; that ordering is what the comparison judges.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int unsigned ARCH_REGS  = 8;
    localparam int unsigned PHYS_REGS  = 128;
    localparam int unsigned ROB_SLOTS  = 126;
    localparam int unsigned GROUP_SIZE = 3;

    // Modular advance used by every ring pointer in the block.
    function automatic int unsigned ring_add(input int unsigned base,
                                             input int unsigned step,
                                             input int unsigned size);
        int unsigned s;
        s = base + step;
        if (s >= size) s = s - size;
        return s;
    endfunction
endpackage

// File: rtl/rn_free_fifo.sv
module rn_free_fifo
    import rn_pkg::*;
#(
    parameter int unsigned NPHYS = PHYS_REGS,
    parameter int unsigned NARCH = ARCH_REGS,
    parameter int unsigned W     = GROUP_SIZE,
    parameter int unsigned PW    = $clog2(NPHYS),
    parameter int unsigned CW    = $clog2(W + 1),
    parameter int unsigned FCW   = $clog2(NPHYS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CW-1:0]          pop_n,
    output logic [W-1:0][PW-1:0]   peek,
    input  logic [W-1:0]           push_v,
    input  logic [W-1:0][PW-1:0]   push_p,
    output logic [FCW-1:0]         free_cnt
);
    localparam int unsigned IW = $clog2(NPHYS);

    logic [PW-1:0] slot_q [NPHYS];
    logic [IW-1:0] rd_q, wr_q;
    logic [FCW-1:0] cnt_q;
    logic [CW-1:0] push_off [W];
    logic [CW-1:0] push_n;

    always_comb begin
        logic [CW-1:0] acc;
        acc = '0;
        for (int k = 0; k < W; k++) begin
            push_off[k] = acc;
            if (push_v[k]) acc = acc + CW'(1);
        end
        push_n = acc;
    end

    for (genvar g = 0; g < W; g++) begin : g_peek
        assign peek[g] = slot_q[IW'(ring_add(32'(rd_q), g, NPHYS))];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++)
                slot_q[i] <= (i < NPHYS - NARCH) ? PW'(i + NARCH) : '0;
            rd_q  <= '0;
            wr_q  <= IW'(NPHYS - NARCH);
            cnt_q <= FCW'(NPHYS - NARCH);
        end else begin
            for (int k = 0; k < W; k++)
                if (push_v[k])
                    slot_q[IW'(ring_add(32'(wr_q), 32'(push_off[k]), NPHYS))] <= push_p[k];
            rd_q  <= IW'(ring_add(32'(rd_q), 32'(pop_n), NPHYS));
            wr_q  <= IW'(ring_add(32'(wr_q), 32'(push_n), NPHYS));
            cnt_q <= cnt_q + FCW'(push_n) - FCW'(pop_n);
        end
    end

    assign free_cnt = cnt_q;

    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        FCW'(pop_n) <= cnt_q);
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (FCW'(pop_n) <= cnt_q) |-> ((cnt_q + FCW'(push_n) - FCW'(pop_n)) <= FCW'(NPHYS - NARCH)));
endmodule

// File: rtl/rn_status_ring.sv
module rn_status_ring
    import rn_pkg::*;
#(
    parameter int unsigned ROBN = ROB_SLOTS,
    parameter int unsigned W    = GROUP_SIZE,
    parameter int unsigned PW   = $clog2(PHYS_REGS),
    parameter int unsigned SW   = $clog2(ROBN),
    parameter int unsigned UW   = $clog2(ROBN + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fire,
    input  logic [W-1:0]          slot_v,
    input  logic [W-1:0]          slot_hasd,
    input  logic [W-1:0][PW-1:0]  slot_oldp,
    output logic [W-1:0][SW-1:0]  alloc_seq,
    output logic [UW-1:0]         used,
    input  logic                  cpl_valid,
    input  logic [SW-1:0]         cpl_seq,
    output logic [W-1:0]          ret_v,
    output logic [W-1:0][SW-1:0]  ret_seq,
    output logic [W-1:0]          ret_hasd,
    output logic [W-1:0][PW-1:0]  ret_oldp
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [ROBN-1:0] done_q;
    logic [ROBN-1:0] hasd_q;
    logic [PW-1:0]   oldp_q [ROBN];
    logic [SW-1:0]   head_q, tail_q;
    logic [UW-1:0]   cnt_q;
    logic [CW-1:0]   alloc_n, ret_n;
    int unsigned     cpl_age;

    always_comb begin
        logic [CW-1:0] acc;
        acc = '0;
        for (int k = 0; k < W; k++) begin
            alloc_seq[k] = SW'(ring_add(32'(tail_q), 32'(acc), ROBN));
            if (slot_v[k]) acc = acc + CW'(1);
        end
        alloc_n = fire ? acc : '0;
    end

    always_comb begin
        logic run;
        logic [CW-1:0] acc;
        logic [SW-1:0] idx;
        run = 1'b1;
        acc = '0;
        for (int k = 0; k < W; k++) begin
            idx         = SW'(ring_add(32'(head_q), k, ROBN));
            ret_v[k]    = run && (UW'(k) < cnt_q) && done_q[idx];
            run         = ret_v[k];
            ret_seq[k]  = idx;
            ret_hasd[k] = hasd_q[idx];
            ret_oldp[k] = oldp_q[idx];
            if (ret_v[k]) acc = acc + CW'(1);
        end
        ret_n = acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= '0;
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (cpl_valid) done_q[cpl_seq] <= 1'b1;
            for (int k = 0; k < W; k++)
                if (fire && slot_v[k]) done_q[alloc_seq[k]] <= 1'b0;
            head_q <= SW'(ring_add(32'(head_q), 32'(ret_n), ROBN));
            tail_q <= SW'(ring_add(32'(tail_q), 32'(alloc_n), ROBN));
            cnt_q  <= cnt_q + UW'(alloc_n) - UW'(ret_n);
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < W; k++)
            if (fire && slot_v[k]) begin
                hasd_q[alloc_seq[k]] <= slot_hasd[k];
                oldp_q[alloc_seq[k]] <= slot_oldp[k];
            end
    end

    assign used = cnt_q;

    always_comb begin
        if (cpl_seq >= head_q) cpl_age = 32'(cpl_seq) - 32'(head_q);
        else                   cpl_age = 32'(cpl_seq) + ROBN - 32'(head_q);
    end

    p_rob_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= UW'(ROBN));
    p_cpl_inflight_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> (cpl_age < 32'(cnt_q)));
endmodule

// File: rtl/rn_alias_table.sv
module rn_alias_table
    import rn_pkg::*;
#(
    parameter int unsigned NARCH = ARCH_REGS,
    parameter int unsigned W     = GROUP_SIZE,
    parameter int unsigned AW    = $clog2(NARCH),
    parameter int unsigned PW    = $clog2(PHYS_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fire,
    input  logic [W-1:0]          wr_v,
    input  logic [W-1:0][AW-1:0]  src_a,
    input  logic [W-1:0][AW-1:0]  src_b,
    input  logic [W-1:0][AW-1:0]  dst,
    input  logic [W-1:0][PW-1:0]  new_p,
    output logic [W-1:0][PW-1:0]  phys_a,
    output logic [W-1:0][PW-1:0]  phys_b,
    output logic [W-1:0][PW-1:0]  prev_p
);
    logic [PW-1:0] map_q [NARCH];

    // Table read with overlay of earlier writers in the group; the nearest wins.
    always_comb begin
        for (int k = 0; k < W; k++) begin
            phys_a[k] = map_q[src_a[k]];
            phys_b[k] = map_q[src_b[k]];
            prev_p[k] = map_q[dst[k]];
            for (int j = 0; j < k; j++) begin
                if (wr_v[j] && dst[j] == src_a[k]) phys_a[k] = new_p[j];
                if (wr_v[j] && dst[j] == src_b[k]) phys_b[k] = new_p[j];
                if (wr_v[j] && dst[j] == dst[k])   prev_p[k] = new_p[j];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NARCH; i++) map_q[i] <= PW'(i);
        end else if (fire) begin
            for (int k = 0; k < W; k++)
                if (wr_v[k]) map_q[dst[k]] <= new_p[k];
        end
    end
endmodule

// File: rtl/rename_alloc.sv
module rename_alloc
    import rn_pkg::*;
#(
    parameter int unsigned NARCH = ARCH_REGS,
    parameter int unsigned NPHYS = PHYS_REGS,
    parameter int unsigned ROBN  = ROB_SLOTS,
    parameter int unsigned W     = GROUP_SIZE,
    localparam int unsigned AW   = $clog2(NARCH),
    localparam int unsigned PW   = $clog2(NPHYS),
    localparam int unsigned SW   = $clog2(ROBN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      grp_valid,
    input  logic [W-1:0]      grp_has_dst,
    input  logic [W*AW-1:0]   grp_src_a,
    input  logic [W*AW-1:0]   grp_src_b,
    input  logic [W*AW-1:0]   grp_dst,
    output logic              grp_stall,
    output logic [W*PW-1:0]   grp_phys_a,
    output logic [W*PW-1:0]   grp_phys_b,
    output logic [W*PW-1:0]   grp_phys_dst,
    output logic [W*SW-1:0]   grp_seq,
    input  logic              done_valid,
    input  logic [SW-1:0]     done_seq,
    output logic [W-1:0]      retire_valid,
    output logic [W*SW-1:0]   retire_seq,
    output logic [W-1:0]      free_valid,
    output logic [W*PW-1:0]   free_preg
);
    localparam int unsigned CW  = $clog2(W + 1);
    localparam int unsigned FCW = $clog2(NPHYS + 1);
    localparam int unsigned UW  = $clog2(ROBN + 1);

    logic [W-1:0][AW-1:0] src_a, src_b, dst;
    logic [W-1:0][PW-1:0] peek, new_p, phys_a, phys_b, prev_p;
    logic [W-1:0][SW-1:0] seq;
    logic [W-1:0]         wr_v, ret_v, ret_hasd;
    logic [W-1:0][SW-1:0] ret_seq;
    logic [W-1:0][PW-1:0] ret_oldp;
    logic [FCW-1:0]       fl_cnt;
    logic [UW-1:0]        rob_used;
    logic [CW-1:0]        pop_n;
    logic                 fire, short_phys, short_rob;

    assign src_a = grp_src_a;
    assign src_b = grp_src_b;
    assign dst   = grp_dst;

    // Resource check on registered occupancy only.
    always_comb begin
        int unsigned nv, nd;
        nv         = $countones(grp_valid);
        nd         = $countones(grp_valid & grp_has_dst);
        short_phys = nd > 32'(fl_cnt);
        short_rob  = nv > ROBN - 32'(rob_used);
        grp_stall  = (nv != 0) && (short_phys || short_rob);
        fire       = (nv != 0) && !grp_stall;
        pop_n      = fire ? CW'(nd) : '0;
    end

    always_comb begin
        logic [CW-1:0] acc;
        acc = '0;
        for (int k = 0; k < W; k++) begin
            wr_v[k]  = grp_valid[k] & grp_has_dst[k];
            new_p[k] = wr_v[k] ? peek[acc] : '0;
            if (wr_v[k]) acc = acc + CW'(1);
        end
    end

    rn_free_fifo #(.NPHYS(NPHYS), .NARCH(NARCH), .W(W), .PW(PW), .CW(CW), .FCW(FCW)) u_free (
        .clk(clk), .rst_n(rst_n), .pop_n(pop_n), .peek(peek),
        .push_v(free_valid), .push_p(ret_oldp), .free_cnt(fl_cnt)
    );

    rn_alias_table #(.NARCH(NARCH), .W(W), .AW(AW), .PW(PW)) u_rat (
        .clk(clk), .rst_n(rst_n), .fire(fire), .wr_v(wr_v),
        .src_a(src_a), .src_b(src_b), .dst(dst), .new_p(new_p),
        .phys_a(phys_a), .phys_b(phys_b), .prev_p(prev_p)
    );

    rn_status_ring #(.ROBN(ROBN), .W(W), .PW(PW), .SW(SW), .UW(UW)) u_ring (
        .clk(clk), .rst_n(rst_n), .fire(fire), .slot_v(grp_valid),
        .slot_hasd(grp_has_dst), .slot_oldp(prev_p), .alloc_seq(seq), .used(rob_used),
        .cpl_valid(done_valid), .cpl_seq(done_seq),
        .ret_v(ret_v), .ret_seq(ret_seq), .ret_hasd(ret_hasd), .ret_oldp(ret_oldp)
    );

    assign grp_phys_a   = phys_a;
    assign grp_phys_b   = phys_b;
    assign grp_phys_dst = new_p;
    assign grp_seq      = seq;
    assign retire_valid = ret_v;
    assign retire_seq   = ret_seq;
    assign free_valid   = ret_v & ret_hasd;
    assign free_preg    = ret_oldp;

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grp_stall |=> $stable(seq[0]));
    p_dst_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && wr_v[0] && wr_v[1]) |-> (new_p[0] != new_p[1]));
endmodule

// File: tb/sim_rename_alloc.sv
module sim_rename_alloc;
    localparam int W = 3, AW = 3, PW = 7, SW = 7, ROBN = 126;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic [W-1:0]      grp_valid, grp_has_dst;
    logic [W*AW-1:0]   grp_src_a, grp_src_b, grp_dst;
    logic              grp_stall;
    logic [W*PW-1:0]   grp_phys_a, grp_phys_b, grp_phys_dst, free_preg;
    logic [W*SW-1:0]   grp_seq, retire_seq;
    logic              done_valid;
    logic [SW-1:0]     done_seq;
    logic [W-1:0]      retire_valid, free_valid;

    rename_alloc u0 (.*);

    int checks = 0, fails = 0;
    int rat [8];
    int fq[$];
    int rseq[$], rdone[$], rhasd[$], roldp[$];
    int pend[$];
    int tail_seq = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_slot(input int k, input bit v, input bit hd, input int a, input int b, input int d);
        grp_valid[k] = v;
        grp_has_dst[k] = hd;
        grp_src_a[k*AW +: AW] = AW'(a);
        grp_src_b[k*AW +: AW] = AW'(b);
        grp_dst[k*AW +: AW] = AW'(d);
    endtask

    task automatic clear_grp();
        grp_valid = '0; grp_has_dst = '0;
        grp_src_a = '0; grp_src_b = '0; grp_dst = '0;
    endtask

    task automatic pick_done(input bit en);
        done_valid = 1'b0;
        if (en && pend.size() > 0) begin
            int i;
            i = $urandom_range(pend.size() - 1, 0);
            done_valid = 1'b1;
            done_seq = SW'(pend[i]);
            pend.delete(i);
        end
    endtask

    // One clock: compare against the model before the edge, then advance the model.
    task automatic cycle();
        int nret, nv, nd, fidx, act;
        int cur [8];
        int nold [3];
        bit exp_stall, fire;
        string tag;
        #2;
        nret = 0;
        while (nret < W && nret < rseq.size() && rdone[nret] == 1) nret++;
        for (int k = 0; k < W; k++) begin
            chk(retire_valid[k] == (k < nret), "R8 retire_valid", int'(retire_valid[k]), int'(k < nret));
            if (k < nret) begin
                act = int'(retire_seq[k*SW +: SW]);
                chk(act == rseq[k], "R8 R7 retire_seq", act, rseq[k]);
                chk(free_valid[k] == rhasd[k][0], "R9 free_valid", int'(free_valid[k]), rhasd[k]);
                if (rhasd[k] == 1) begin
                    act = int'(free_preg[k*PW +: PW]);
                    chk(act == roldp[k], "R9 free_preg", act, roldp[k]);
                end
            end else begin
                chk(free_valid[k] == 1'b0, "R9 free_valid idle", int'(free_valid[k]), 0);
            end
        end
        nv = 0; nd = 0;
        for (int k = 0; k < W; k++) begin
            if (grp_valid[k]) nv++;
            if (grp_valid[k] && grp_has_dst[k]) nd++;
        end
        exp_stall = (nv > 0) && (nd > fq.size() || nv > ROBN - rseq.size());
        if (exp_stall) tag = (nd > fq.size()) ? "R5 stall" : "R6 stall";
        else tag = (nv > 0 && nd == 0 && fq.size() == 0) ? "R10 no-dst accept" : "R5 R6 stall";
        chk(grp_stall == exp_stall, tag, int'(grp_stall), int'(exp_stall));
        fire = (nv > 0) && !exp_stall;
        fidx = 0;
        for (int i = 0; i < 8; i++) cur[i] = rat[i];
        if (fire) begin
            int j;
            j = 0;
            for (int k = 0; k < W; k++) begin
                nold[k] = -1;
                if (grp_valid[k]) begin
                    int e;
                    act = int'(grp_phys_a[k*PW +: PW]);
                    e = cur[grp_src_a[k*AW +: AW]];
                    chk(act == e, "R2 phys_a", act, e);
                    act = int'(grp_phys_b[k*PW +: PW]);
                    e = cur[grp_src_b[k*AW +: AW]];
                    chk(act == e, "R2 phys_b", act, e);
                    act = int'(grp_seq[k*SW +: SW]);
                    e = (tail_seq + j) % ROBN;
                    chk(act == e, "R4 seq", act, e);
                    j++;
                    if (grp_has_dst[k]) begin
                        act = int'(grp_phys_dst[k*PW +: PW]);
                        e = fq[fidx];
                        chk(act == e, "R3 phys_dst", act, e);
                        fidx++;
                        nold[k] = cur[grp_dst[k*AW +: AW]];
                        cur[grp_dst[k*AW +: AW]] = e;
                    end
                end
            end
        end
        @(posedge clk);
        begin
            int freed[$];
            for (int k = 0; k < nret; k++) begin
                if (rhasd[0] == 1) freed.push_back(roldp[0]);
                void'(rseq.pop_front()); void'(rdone.pop_front());
                void'(rhasd.pop_front()); void'(roldp.pop_front());
            end
            if (fire) begin
                for (int k = 0; k < fidx; k++) void'(fq.pop_front());
                for (int k = 0; k < W; k++)
                    if (grp_valid[k]) begin
                        rseq.push_back(tail_seq); rdone.push_back(0);
                        rhasd.push_back(int'(grp_has_dst[k])); roldp.push_back(nold[k]);
                        pend.push_back(tail_seq);
                        tail_seq = (tail_seq + 1) % ROBN;
                    end
                for (int i = 0; i < 8; i++) rat[i] = cur[i];
            end
            foreach (freed[i]) fq.push_back(freed[i]);
            if (done_valid)
                foreach (rseq[i]) if (rseq[i] == int'(done_seq)) rdone[i] = 1;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        clear_grp();
        done_valid = 1'b0; done_seq = '0;
        for (int i = 0; i < 8; i++) rat[i] = i;
        for (int p = 8; p < 128; p++) fq.push_back(p);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(grp_stall == 1'b0, "R1 reset stall", int'(grp_stall), 0);
        chk(retire_valid == '0, "R1 reset retire", int'(retire_valid), 0);
        @(negedge clk);

        // Directed group exercising the same-group bypass.
        set_slot(0, 1, 1, 1, 2, 5);
        set_slot(1, 1, 1, 5, 5, 5);
        set_slot(2, 1, 1, 3, 5, 0);
        #1;
        chk(int'(grp_phys_a[0 +: PW]) == 1, "R1 reset map", int'(grp_phys_a[0 +: PW]), 1);
        chk(int'(grp_phys_dst[0 +: PW]) == 8, "R1 first free", int'(grp_phys_dst[0 +: PW]), 8);
        chk(int'(grp_phys_b[2*PW +: PW]) == 9, "R2 nearest bypass", int'(grp_phys_b[2*PW +: PW]), 9);
        cycle();

        // Exhaust the free list, then fill the ring with no-destination groups.
        for (int c = 0; c < 45; c++) begin
            for (int k = 0; k < W; k++) set_slot(k, 1, 1, $urandom % 8, $urandom % 8, $urandom % 8);
            cycle();
        end
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < W; k++) set_slot(k, 1, 0, $urandom % 8, $urandom % 8, 0);
            cycle();
        end

        // Drain with out-of-order completions.
        clear_grp();
        for (int c = 0; c < 170; c++) begin
            pick_done(1'b1);
            cycle();
        end

        // Mixed traffic: allocation and retirement overlap.
        for (int c = 0; c < 3000; c++) begin
            for (int k = 0; k < W; k++) begin
                int pool;
                pool = (c % 3 == 0) ? 8 : 4;
                set_slot(k, ($urandom % 4) != 0, ($urandom % 3) != 0,
                         $urandom % pool, $urandom % pool, $urandom % pool);
            end
            pick_done(($urandom % 5) != 0);
            cycle();
        end

        clear_grp();
        for (int c = 0; c < 200; c++) begin
            pick_done(1'b1);
            cycle();
        end
        done_valid = 1'b0;
        #2;
        chk(retire_valid == '0, "R8 drained", int'(retire_valid), 0);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule